// File: doc/BRIEF.md
# Fetch-Stage Branch Target Table

This block predicts where instruction fetch goes next. Each cycle it takes the current fetch address and looks it up in a direct-mapped table. The lookup is combinational, so it runs alongside the instruction cache access. A slot holds a valid flag, the upper address bits as a tag, and a recorded destination address. The block returns a hit flag and the stored destination.

An external direction predictor supplies a taken/not-taken guess. The block combines that guess with the hit and produces the next fetch address. This is the stored destination when the table hits and the guess is taken, and the sequential address (current plus 4) in every other case.

Entries are written through a separate update port. The pipeline drives that port only when a branch that was actually taken commits. Not-taken branches never occupy a slot.

Top module: `fetch_target_cache`

## Requirements
- R1: The slot is selected by fetch_pc[IDX_W+1:2] (bits 5:2 by default). The tag is fetch_pc[PC_W-1:IDX_W+2]. Two addresses with the same slot bits but different tags never hit on each other's entry.
- R2: After reset every slot is invalid, so no address hits until an update has been made.
- R3: An update with upd_en high stores upd_target for upd_pc at the clock edge. A lookup of upd_pc in any later cycle hits and returns that target on pred_target.
- R4: hit, pred_target and next_pc follow fetch_pc and dir_taken in the same cycle, with no register in the lookup path.
- R5: When hit is high and dir_taken is high, next_pc equals pred_target.
- R6: When hit is low or dir_taken is low, next_pc equals fetch_pc + 4.
- R7: With upd_en low, the values on upd_pc and upd_target change no slot, so a not-taken branch allocates nothing.
- R8: A lookup in the same cycle as an update to the same slot sees the slot's contents from before that update.
- R9: An update replaces whatever the selected slot held. An address that previously hit in that slot but carries a different tag then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| dir_taken | input | 1 | Direction guess from the external predictor (1 = taken) |
| upd_en | input | 1 | Write strobe for a committed taken branch |
| upd_pc | input | PC_W | Address of the committed branch |
| upd_target | input | PC_W | Destination of the committed branch |
| hit | output | 1 | Slot valid and tag matches fetch_pc |
| pred_target | output | PC_W | Stored destination of the selected slot |
| next_pc | output | PC_W | Address to fetch in the next cycle |

## Verification
All three lookup results are due in the same cycle as the address that produces them. An update becomes visible only from the cycle after the clock edge that accepts it. The bench drives each stimulus on the falling edge and samples the outputs a quarter period later, before the next rising edge. It computes each expected value from a model that has not yet applied that cycle's update, which exercises the no-forwarding rule directly. The model applies the update only after the comparison, matching the edge at which the table changes.

// File: rtl/fetch_target_cache.sv
module fetch_target_cache #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            dir_taken,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  output logic            hit,
  output logic [PC_W-1:0] pred_target,
  output logic [PC_W-1:0] next_pc
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];

  wire [IDX_W-1:0] rd_idx  = fetch_pc[IDX_W+1:2];
  wire [TAG_W-1:0] rd_tag  = fetch_pc[PC_W-1:IDX_W+2];
  wire [IDX_W-1:0] wr_idx  = upd_pc[IDX_W+1:2];
  wire [TAG_W-1:0] wr_tag  = upd_pc[PC_W-1:IDX_W+2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      vld <= '0;
    else if (upd_en) vld[wr_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (upd_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= upd_target;
    end

  assign hit         = vld[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign pred_target = tgt_q[rd_idx];
  assign next_pc     = (hit && dir_taken) ? pred_target : fetch_pc + PC_W'(4);
endmodule

module fetch_target_cache_chk #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            dir_taken,
  input logic            upd_en,
  input logic [PC_W-1:0] upd_pc,
  input logic [PC_W-1:0] upd_target,
  input logic            hit,
  input logic [PC_W-1:0] pred_target,
  input logic [PC_W-1:0] next_pc
);
  // R2
  cold_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !hit);
  // R3
  fill_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en ##1 (fetch_pc == $past(upd_pc)) |-> hit && pred_target == $past(upd_target));
  // R5
  taken_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && dir_taken |-> next_pc == pred_target);
  // R6
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && dir_taken) |-> next_pc == fetch_pc + PC_W'(4));
  // R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(upd_en) && $stable(fetch_pc) |-> $stable(hit));
endmodule

bind fetch_target_cache fetch_target_cache_chk #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_fetch_target_cache.sv
module sim_fetch_target_cache;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  typedef struct {
    logic            hit;
    logic [PC_W-1:0] tgt;
    logic [PC_W-1:0] nxt;
    string           req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic dir_taken = 0, upd_en = 0;
  logic hit;
  logic [PC_W-1:0] pred_target, next_pc;

  int errors = 0, checks = 0;
  bit done = 0;
  exp_t q[$];
  event smp;

  bit              m_vld [DEPTH];
  logic [PC_W-1:0] m_pc  [DEPTH];
  logic [PC_W-1:0] m_tgt [DEPTH];

  always #10 clk = ~clk;

  fetch_target_cache #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (.*);

  always @(smp) begin
    exp_t e;
    e = q.pop_front();
    checks++;
    if (hit !== e.hit || next_pc !== e.nxt || (e.hit && pred_target !== e.tgt)) begin
      errors++;
      $display("FAIL %s: hit=%0b tgt=%h nxt=%h expected hit=%0b tgt=%h nxt=%h",
               e.req, hit, pred_target, next_pc, e.hit, e.tgt, e.nxt);
    end
  end

  task automatic step(input logic [PC_W-1:0] pc, input logic tk, input logic we,
                      input logic [PC_W-1:0] wpc, input logic [PC_W-1:0] wtgt, input string req);
    exp_t e;
    int i;
    @(negedge clk);
    fetch_pc = pc; dir_taken = tk; upd_en = we; upd_pc = wpc; upd_target = wtgt;
    i = int'(pc[IDX_W+1:2]);
    e.hit = m_vld[i] && m_pc[i][PC_W-1:IDX_W+2] == pc[PC_W-1:IDX_W+2];
    e.tgt = m_tgt[i];
    e.nxt = (e.hit && tk) ? m_tgt[i] : pc + 4;
    e.req = req;
    q.push_back(e);
    #5 -> smp;
    if (we) begin
      i = int'(wpc[IDX_W+1:2]);
      m_vld[i] = 1; m_pc[i] = wpc; m_tgt[i] = wtgt;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(32'h100, 1, 0, 0, 0, "R2 reset miss");
    step(32'h1000, 1, 0, 0, 0, "R6 miss sequential");
    step(32'h1000, 1, 1, 32'h1000, 32'h2000, "R8 no forward");
    step(32'h1000, 1, 0, 0, 0, "R3 R4 R5 hit taken");
    step(32'h1000, 0, 0, 0, 0, "R6 hit not taken");
    step(32'h1040, 1, 0, 0, 0, "R1 alias miss");
    step(32'h3008, 1, 0, 32'h3008, 32'h7777, "R7 no write");
    step(32'h3008, 1, 0, 0, 0, "R7 still miss");
    step(32'h1040, 1, 1, 32'h1040, 32'h5000, "R8 write alias");
    step(32'h1000, 1, 0, 0, 0, "R9 evicted miss");
    step(32'h1040, 1, 0, 0, 0, "R9 new hit");
    for (int i = 0; i < DEPTH; i++)
      step(32'h8000 + i*4, 1, 1, 32'h8000 + i*4, 32'h40000 + i*256, "R3 fill");
    for (int i = 0; i < DEPTH; i++)
      step(32'h8000 + i*4, i % 3 != 0, 0, 0, 0, "R4 R5 R6 sweep");
    for (int i = 0; i < DEPTH; i++)
      step(32'h9000 + i*4, 1, 0, 0, 0, "R1 tag mismatch");
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule